// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block runs programmed-I/O cycles on one IDE channel that carries two drives. For each accepted request it goes through an address setup phase, a strobe phase and a recovery phase. The length of each phase is counted in bus clocks. The read strobe (`ide_dior_n`) or the write strobe (`ide_diow_n`) is driven low only during the strobe phase. At the end of the cycle `done` pulses, and for a read the captured drive data is returned with it.

Each drive has its own setup length. It also has its own strobe and recovery lengths, which apply to accesses to the data register (task-file offset 0). Accesses to any other task-file register use one strobe and recovery pair that is shared by the whole channel and is normally slower. A small write-only configuration port loads these fields. They reset to conservative values.

Requests enter through a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request that is offered while a cycle is in progress, including during its recovery phase, stays pending with `req_valid` high until `req_ready` returns. The completion side has no back-pressure: `done` is a single-clock pulse, and `rd_data` holds its value until the next read completes.

Top module: `ide_pio_strobe`

## Requirements
- R1: While `rst_n` is low and just after reset, `ide_dior_n`, `ide_diow_n` and `ide_cs_n` are high, `req_ready` is high and `done` is low.
- R2: An accepted request gives a cycle with three phases in this order: setup (`ide_cs_n` low, both strobes high), strobe (one strobe low), recovery (`ide_cs_n` low, both strobes high). The next clock is idle, with `done` high for exactly one clock. During the cycle, `ide_da` equals the requested register.
- R3: The setup phase lasts the selected drive's 2-bit setup field plus one clocks (00 gives 1 clock, 11 gives 4 clocks). The setup fields are written at configuration address 1: drive 0 in `cfg_wdata[3:2]` and drive 1 in `cfg_wdata[1:0]`. Both reset to 11.
- R4: For data-register accesses (`req_reg` = 0), the strobe and recovery phases last the selected drive's 4-bit strobe and recovery fields plus one clocks. These fields are written at configuration address 0: drive 0 uses byte `cfg_wdata[15:8]`, drive 1 uses byte `cfg_wdata[7:0]`, with the strobe field in the upper nibble and the recovery field in the lower nibble. They reset to strobe 1010b (11 clocks) and recovery 1000b (9 clocks).
- R5: For accesses with `req_reg` other than 0, the strobe and recovery phases use the channel-wide pair written at configuration address 2: strobe in `cfg_wdata[7:4]` and recovery in `cfg_wdata[3:0]`, each meaning the value plus one clocks. Both reset to 1111b (16 clocks). Setup still comes from the selected drive.
- R6: For a read, `rd_data` holds the value of `ide_dd_in` from the last clock of the strobe phase and is valid when `done` is high.
- R7: For a write, `ide_dd_oe` is high and `ide_dd_out` equals `req_wdata` from the first setup clock to the last strobe clock. `ide_dd_oe` is low during recovery and during reads.
- R8: A request is accepted only when `req_ready` is high, and that happens only in idle. A request offered during a cycle waits until that cycle's `done` clock, and every offered request completes.
- R9: The phase lengths are taken when the request is accepted. Configuration writes made during a cycle take effect from the next cycle.
- R10: Reads drive only `ide_dior_n` and writes drive only `ide_diow_n`. The two strobes are never low at the same time.
- R11: A configuration write to address 3 changes no timing field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field group (0 drive timing, 1 setup, 2 channel non-data timing) |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken this clock if valid |
| req_drive | input | 1 | Drive selecting the timing set |
| req_write | input | 1 | 1 for write, 0 for read |
| req_reg | input | 3 | Task-file register offset, 0 is the data register |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock cycle completion pulse |
| rd_data | output | 16 | Data captured by the last read |
| ide_cs_n | output | 1 | Chip select, low for the whole cycle |
| ide_da | output | 3 | Register address on the cable |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dd_out | output | 16 | Data driven to the cable |
| ide_dd_oe | output | 1 | Output enable for `ide_dd_out` |
| ide_dd_in | input | 16 | Data from the cable |

## Verification
The hardest case to reach is a configuration write that lands inside an active cycle, while a second request is already waiting for the same sequencer. The stimulus reaches it in two steps. It accepts a short data-register write, and on the very next clock, which is still in setup, it reprograms drive 0's strobe and recovery. It then offers a read at once. That read stays pending through the whole first cycle, and it has to come out with the new lengths while the first cycle keeps the old ones. `ide_dd_in` changes every clock, so the captured read word shows which strobe clock was sampled.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  localparam logic [1:0] CFG_DRV_TIMING = 2'd0;
  localparam logic [1:0] CFG_SETUP      = 2'd1;
  localparam logic [1:0] CFG_NONDATA    = 2'd2;

endpackage

// File: rtl/ide_pio_timing_regs.sv
module ide_pio_timing_regs #(
  parameter int NUM_DRIVES = 2,
  parameter int FIELD_W    = 4,
  parameter int SETUP_W    = 2,
  parameter int CFG_W      = 16,
  parameter logic [FIELD_W-1:0] ACT_RST    = 4'hA,
  parameter logic [FIELD_W-1:0] REC_RST    = 4'h8,
  parameter logic [SETUP_W-1:0] SETUP_RST  = 2'b11,
  parameter logic [FIELD_W-1:0] NP_ACT_RST = 4'hF,
  parameter logic [FIELD_W-1:0] NP_REC_RST = 4'hF
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [1:0]                          cfg_addr,
  input  logic [CFG_W-1:0]                    cfg_wdata,
  output logic [NUM_DRIVES-1:0][FIELD_W-1:0]  drv_act,
  output logic [NUM_DRIVES-1:0][FIELD_W-1:0]  drv_rec,
  output logic [NUM_DRIVES-1:0][SETUP_W-1:0]  drv_setup,
  output logic [FIELD_W-1:0]                  np_act,
  output logic [FIELD_W-1:0]                  np_rec
);
  import ide_pio_pkg::*;

  localparam int PAIR_W = 2 * FIELD_W;

  logic wr_drv, wr_setup, wr_np;
  assign wr_drv   = cfg_we && (cfg_addr == CFG_DRV_TIMING);
  assign wr_setup = cfg_we && (cfg_addr == CFG_SETUP);
  assign wr_np    = cfg_we && (cfg_addr == CFG_NONDATA);

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    localparam int PLO = (NUM_DRIVES - 1 - d) * PAIR_W;
    localparam int SLO = (NUM_DRIVES - 1 - d) * SETUP_W;
    logic [FIELD_W-1:0] act_q, rec_q;
    logic [SETUP_W-1:0] set_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= ACT_RST;
        rec_q <= REC_RST;
      end else if (wr_drv) begin
        act_q <= cfg_wdata[PLO+FIELD_W +: FIELD_W];
        rec_q <= cfg_wdata[PLO +: FIELD_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) set_q <= SETUP_RST;
      else if (wr_setup) set_q <= cfg_wdata[SLO +: SETUP_W];
    end

    assign drv_act[d]   = act_q;
    assign drv_rec[d]   = rec_q;
    assign drv_setup[d] = set_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      np_act <= NP_ACT_RST;
      np_rec <= NP_REC_RST;
    end else if (wr_np) begin
      np_act <= cfg_wdata[FIELD_W +: FIELD_W];
      np_rec <= cfg_wdata[0 +: FIELD_W];
    end
  end

endmodule

// File: rtl/ide_pio_timing_sel.sv
module ide_pio_timing_sel #(
  parameter int NUM_DRIVES = 2,
  parameter int FIELD_W    = 4,
  parameter int SETUP_W    = 2,
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic [NUM_DRIVES-1:0][FIELD_W-1:0]  drv_act,
  input  logic [NUM_DRIVES-1:0][FIELD_W-1:0]  drv_rec,
  input  logic [NUM_DRIVES-1:0][SETUP_W-1:0]  drv_setup,
  input  logic [FIELD_W-1:0]                  np_act,
  input  logic [FIELD_W-1:0]                  np_rec,
  input  logic [DRV_W-1:0]                    drive,
  input  logic                                is_data,
  output logic [FIELD_W-1:0]                  t_setup,
  output logic [FIELD_W-1:0]                  t_act,
  output logic [FIELD_W-1:0]                  t_rec
);

  always_comb begin
    t_setup = {{(FIELD_W-SETUP_W){1'b0}}, drv_setup[drive]};
    if (is_data) begin
      t_act = drv_act[drive];
      t_rec = drv_rec[drive];
    end else begin
      t_act = np_act;
      t_rec = np_rec;
    end
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq #(
  parameter int DATA_W     = 16,
  parameter int REG_ADDR_W = 3,
  parameter int FIELD_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [REG_ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [FIELD_W-1:0]    t_setup,
  input  logic [FIELD_W-1:0]    t_act,
  input  logic [FIELD_W-1:0]    t_rec,
  input  logic [DATA_W-1:0]     ide_dd_in,
  output logic                  done,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  ide_cs_n,
  output logic [REG_ADDR_W-1:0] ide_da,
  output logic                  ide_dior_n,
  output logic                  ide_diow_n,
  output logic [DATA_W-1:0]     ide_dd_out,
  output logic                  ide_dd_oe
);
  import ide_pio_pkg::*;

  phase_e               ph_q;
  logic [FIELD_W-1:0]   cnt_q;
  logic [FIELD_W-1:0]   act_q, rec_q;
  logic                 wr_q;
  logic [REG_ADDR_W-1:0] reg_q;
  logic [DATA_W-1:0]    wdata_q;
  logic                 done_q;
  logic                 last_clk;
  logic                 accept;

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_clk  = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      wr_q    <= 1'b0;
      reg_q   <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            ph_q    <= PH_SETUP;
            cnt_q   <= t_setup;
            act_q   <= t_act;
            rec_q   <= t_rec;
            wr_q    <= req_write;
            reg_q   <= req_reg;
            wdata_q <= req_wdata;
          end
        end
        PH_SETUP: begin
          if (last_clk) begin
            ph_q  <= PH_ACTIVE;
            cnt_q <= act_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (last_clk) begin
            ph_q  <= PH_RECOV;
            cnt_q <= rec_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_RECOV: begin
          if (last_clk) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (ph_q == PH_ACTIVE && last_clk && !wr_q) rd_data <= ide_dd_in;
  end

  assign done       = done_q;
  assign ide_cs_n   = (ph_q == PH_IDLE);
  assign ide_da     = reg_q;
  assign ide_dior_n = !((ph_q == PH_ACTIVE) && !wr_q);
  assign ide_diow_n = !((ph_q == PH_ACTIVE) && wr_q);
  assign ide_dd_oe  = wr_q && ((ph_q == PH_SETUP) || (ph_q == PH_ACTIVE));
  assign ide_dd_out = wdata_q;

endmodule

// File: rtl/ide_pio_strobe.sv
module ide_pio_strobe #(
  parameter int NUM_DRIVES = 2,
  parameter int DATA_W     = 16,
  parameter int REG_ADDR_W = 3,
  parameter int FIELD_W    = 4,
  parameter int SETUP_W    = 2,
  parameter int CFG_W      = 16,
  parameter int DATA_REG   = 0,
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_addr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [DRV_W-1:0]      req_drive,
  input  logic                  req_write,
  input  logic [REG_ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  done,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  ide_cs_n,
  output logic [REG_ADDR_W-1:0] ide_da,
  output logic                  ide_dior_n,
  output logic                  ide_diow_n,
  output logic [DATA_W-1:0]     ide_dd_out,
  output logic                  ide_dd_oe,
  input  logic [DATA_W-1:0]     ide_dd_in
);

  logic [NUM_DRIVES-1:0][FIELD_W-1:0] drv_act, drv_rec;
  logic [NUM_DRIVES-1:0][SETUP_W-1:0] drv_setup;
  logic [FIELD_W-1:0] np_act, np_rec;
  logic [FIELD_W-1:0] t_setup, t_act, t_rec;
  logic is_data;

  assign is_data = (req_reg == REG_ADDR_W'(DATA_REG));

  ide_pio_timing_regs #(
    .NUM_DRIVES(NUM_DRIVES), .FIELD_W(FIELD_W), .SETUP_W(SETUP_W), .CFG_W(CFG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .drv_act(drv_act), .drv_rec(drv_rec),
    .drv_setup(drv_setup), .np_act(np_act), .np_rec(np_rec)
  );

  ide_pio_timing_sel #(
    .NUM_DRIVES(NUM_DRIVES), .FIELD_W(FIELD_W), .SETUP_W(SETUP_W)
  ) u_sel (
    .drv_act(drv_act), .drv_rec(drv_rec), .drv_setup(drv_setup),
    .np_act(np_act), .np_rec(np_rec), .drive(req_drive), .is_data(is_data),
    .t_setup(t_setup), .t_act(t_act), .t_rec(t_rec)
  );

  ide_pio_seq #(
    .DATA_W(DATA_W), .REG_ADDR_W(REG_ADDR_W), .FIELD_W(FIELD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
    .t_setup(t_setup), .t_act(t_act), .t_rec(t_rec), .ide_dd_in(ide_dd_in),
    .done(done), .rd_data(rd_data), .ide_cs_n(ide_cs_n), .ide_da(ide_da),
    .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
    .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe)
  );

endmodule

// File: rtl/ide_pio_strobe_chk.sv
module ide_pio_strobe_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              ide_cs_n,
  input logic              ide_dior_n,
  input logic              ide_diow_n,
  input logic              ide_dd_oe,
  input logic [DATA_W-1:0] ide_dd_out
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (ide_dior_n && ide_diow_n && ide_cs_n));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ide_cs_n && req_ready));

  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_dior_n || !ide_diow_n) |-> !ide_cs_n);

  p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_cs_n) |-> (ide_dior_n && ide_diow_n));

  p_oe_not_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ide_dd_oe |-> ide_dior_n);

  p_wdata_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_dd_oe && $past(ide_dd_oe)) |-> $stable(ide_dd_out));

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !ide_cs_n));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_dior_n && !ide_diow_n));

endmodule

bind ide_pio_strobe ide_pio_strobe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .ide_cs_n(ide_cs_n), .ide_dior_n(ide_dior_n),
  .ide_diow_n(ide_diow_n), .ide_dd_oe(ide_dd_oe), .ide_dd_out(ide_dd_out)
);

// File: tb/ide_pio_strobe_tb.sv
module ide_pio_strobe_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [0:0]  req_drive = '0;
  logic        req_write = 1'b0;
  logic [2:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rd_data;
  logic        ide_cs_n;
  logic [2:0]  ide_da;
  logic        ide_dior_n, ide_diow_n;
  logic [15:0] ide_dd_out;
  logic        ide_dd_oe;
  logic [15:0] ide_dd_in = 16'hACE1;

  always #2 clk = ~clk;

  ide_pio_strobe u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_drive(req_drive), .req_write(req_write), .req_reg(req_reg),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .ide_cs_n(ide_cs_n), .ide_da(ide_da), .ide_dior_n(ide_dior_n),
    .ide_diow_n(ide_diow_n), .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe),
    .ide_dd_in(ide_dd_in)
  );

  typedef struct {
    int          su, act, rec;
    logic        wr;
    logic [2:0]  rg;
    logic [15:0] wd;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0, n_sent = 0, n_done = 0;
  bit finished = 0;

  // bench copy of the programmed fields, from the requirements
  logic [3:0] m_act[2], m_rec[2];
  logic [1:0] m_set[2];
  logic [3:0] m_np_act, m_np_rec;

  task automatic chk(string req, string what, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // cable data changes shortly after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    ide_dd_in = {ide_dd_in[14:0], ide_dd_in[15] ^ ide_dd_in[13] ^ ide_dd_in[12] ^ ide_dd_in[10]};
  end

  task automatic cfg_write(logic [1:0] a, logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    case (a)
      2'd0: begin m_act[0] = v[15:12]; m_rec[0] = v[11:8]; m_act[1] = v[7:4]; m_rec[1] = v[3:0]; end
      2'd1: begin m_set[0] = v[3:2]; m_set[1] = v[1:0]; end
      2'd2: begin m_np_act = v[7:4]; m_np_rec = v[3:0]; end
      default: ;  // R11: address 3 leaves every field alone
    endcase
  endtask

  // driver: pushes the expected item then offers the request
  task automatic send(int drv, bit wr, logic [2:0] rg, logic [15:0] wd);
    exp_t e;
    e.su = int'(m_set[drv]) + 1;
    if (rg == 3'd0) begin
      e.act = int'(m_act[drv]) + 1; e.rec = int'(m_rec[drv]) + 1;
    end else begin
      e.act = int'(m_np_act) + 1;   e.rec = int'(m_np_rec) + 1;
    end
    e.wr = wr; e.rg = rg; e.wd = wd;
    exp_q.push_back(e);
    n_sent++;
    @(negedge clk);
    req_valid = 1'b1; req_drive = 1'(drv); req_write = wr; req_reg = rg; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor state
  int mo_su = 0, mo_act = 0, mo_rec = 0;
  bit b_ready = 0, b_oe = 0, b_strobe = 0, b_order = 0, b_da = 0, prev_done = 0;
  logic [15:0] mo_last_in = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!ide_cs_n && exp_q.size() != 0) begin
        exp_t c;
        bit on, in_rec;
        c = exp_q[0];
        if (req_ready) b_ready = 1;
        if (ide_da != c.rg) b_da = 1;
        if (c.wr ? !ide_dior_n : !ide_diow_n) b_strobe = 1;
        on = c.wr ? !ide_diow_n : !ide_dior_n;
        in_rec = !on && (mo_act > 0);
        if (c.wr) begin
          if (!in_rec) begin
            if (!ide_dd_oe || ide_dd_out != c.wd) b_oe = 1;
          end else if (ide_dd_oe) b_oe = 1;
        end else if (ide_dd_oe) b_oe = 1;
        if (on) begin
          if (mo_rec > 0) b_order = 1;
          mo_act++;
          mo_last_in = ide_dd_in;
        end else if (mo_act == 0) mo_su++;
        else mo_rec++;
      end
      if (done) begin
        chk("R2", "done lasts one clock", int'(prev_done), 0);
        if (exp_q.size() == 0) begin
          chk("R8", "done without request", 1, 0);
        end else begin
          exp_t c;
          string tg;
          c = exp_q.pop_front();
          n_done++;
          tg = (c.rg == 3'd0) ? "R4" : "R5";
          chk("R3", "setup clocks", mo_su, c.su);
          chk(tg, "strobe clocks", mo_act, c.act);
          chk(tg, "recovery clocks", mo_rec, c.rec);
          chk("R2", "phase order and address", int'(b_order | b_da), 0);
          chk("R8", "ready low while busy", int'(b_ready), 0);
          chk("R10", "strobe selection", int'(b_strobe), 0);
          chk("R7", "data drive window", int'(b_oe), 0);
          if (!c.wr) chk("R6", "read data", int'(rd_data), int'(mo_last_in));
        end
        mo_su = 0; mo_act = 0; mo_rec = 0;
        b_ready = 0; b_oe = 0; b_strobe = 0; b_order = 0; b_da = 0;
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    m_act[0] = 4'hA; m_act[1] = 4'hA; m_rec[0] = 4'h8; m_rec[1] = 4'h8;
    m_set[0] = 2'b11; m_set[1] = 2'b11; m_np_act = 4'hF; m_np_rec = 4'hF;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk("R1", "dior_n in reset", int'(ide_dior_n), 1);
    chk("R1", "diow_n in reset", int'(ide_diow_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cs_n after reset", int'(ide_cs_n), 1);
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "done after reset", int'(done), 0);

    // default timings: R3 4 clocks, R4 11/9, R5 16/16
    send(0, 0, 3'd0, 16'h0000); drain();
    send(1, 1, 3'd0, 16'h5A3C); drain();
    send(0, 0, 3'd7, 16'h0000); drain();
    send(1, 1, 3'd3, 16'hC001); drain();

    // reprogram: drive 0 strobe 3 rec 2, drive 1 1/1; setup d0 1, d1 3
    cfg_write(2'd0, 16'h2100);
    cfg_write(2'd1, 16'h0002);
    send(0, 1, 3'd0, 16'h1234); drain();
    send(1, 0, 3'd0, 16'h0000); drain();
    cfg_write(2'd2, 16'h0000);   // R5 channel pair 1/1
    send(1, 1, 3'd2, 16'hBEEF); drain();
    send(0, 0, 3'd1, 16'h0000); drain();

    // R11: address 3 ignored
    cfg_write(2'd3, 16'hFFFF);
    send(0, 0, 3'd0, 16'h0000); drain();
    send(1, 0, 3'd6, 16'h0000); drain();

    // R9 and R8: reprogram during a cycle, next request waits through it
    send(0, 1, 3'd0, 16'h8421);
    cfg_write(2'd0, 16'hFF00);
    send(0, 0, 3'd0, 16'h0000);
    send(1, 0, 3'd0, 16'h0000);
    send(1, 1, 3'd0, 16'h7777);
    drain();

    // boundary: longest setup and strobe
    cfg_write(2'd1, 16'h000F);
    send(0, 0, 3'd0, 16'h0000); drain();
    send(1, 1, 3'd0, 16'hFFFF); drain();

    repeat (4) @(negedge clk);
    chk("R8", "all requests completed", n_done, n_sent);
    chk("R1", "idle strobes at end", int'(ide_dior_n & ide_diow_n), 1);
    finished = 1;
    summary();
    $finish;
  end

endmodule